// File: doc/BRIEF.md
# Character Page Window Register File

This block holds the eight bank registers that map the video side's 8 KB pattern space onto a larger character memory. The video address space from 0x0000 to 0x1FFF is cut into eight 1 KB windows. Each window has one 8-bit register that names which 1 KB page of character memory is seen through it. A lookup port takes a video address and returns, with no clock delay, the page currently mapped at that address.

The CPU writes each bank register one nibble at a time. There are four register pairs, one pair per 4 KB block of CPU address space: 0xB000, 0xC000, 0xD000 and 0xE000. Inside a pair, small offsets from the block base select the nibble. Most nibble slots also answer at a second, aliased offset. Any address that is not one of these slots is ignored. The page output is masked to the number of character pages the memory actually holds.

Top module: `tile_page_map`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears all eight bank registers to 0, so every window then reads page 0.
- R2: `pageNum` shows the register selected by `vidAddr[12:10]`: register n serves video addresses n×0x400 to n×0x400+0x3FF, and `vidAddr[9:0]` has no effect.
- R3: Register pair k (k=0..3) has CPU base 0xB000, 0xC000, 0xD000 or 0xE000 and holds registers 2k (even) and 2k+1 (odd). A write to base+0x0 loads the low nibble of the even register.
- R4: A write to base+0x2, or to its alias base+0x8, loads the high nibble of the even register.
- R5: A write to base+0x1, or to its alias base+0x4, loads the low nibble of the odd register.
- R6: A write to base+0x3, or to its alias base+0xC, loads the high nibble of the odd register.
- R7: A nibble write stores `wrData[3:0]` in the addressed nibble. `wrData[7:4]` is ignored, and the other nibble of that register keeps its value.
- R8: A write to any other address changes no register. This covers other offsets within a base (for example 0x5, 0x6 or 0x10) and addresses outside 0xB000–0xEFFF.
- R9: A write sampled at a clock edge changes `pageNum` only after that edge. Just before the edge, `pageNum` still shows the old value.
- R10: `pageNum` is the register value ANDed with 2^PAGE_BITS−1. With the default PAGE_BITS=7, bit 7 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | CPU write strobe, sampled at the rising edge |
| wrAddr | input | 16 | CPU write address |
| wrData | input | 8 | CPU write data; only bits 3:0 are used |
| vidAddr | input | 13 | Video address to look up |
| pageNum | output | 8 | 1 KB character page mapped at `vidAddr`, masked |

## Verification
The checker covers the properties that can be tested on every cycle:
- the cleared state after reset;
- that `pageNum` holds when no write is accepted and the lookup address is unchanged, including across writes to unused addresses;
- the nibble placement for the primary low slot of register 0 and the high alias of register 7;
- the page mask.

Only the bench scenarios can show the following:
- the full slot map with every alias across all four pairs;
- that each window really selects its own register;
- that the other nibble is preserved;
- the exact edge at which a new value becomes visible.

// File: rtl/tpm_pkg.sv
package tpm_pkg;
  localparam int REG_W = 8;
  localparam int NIB_W = REG_W / 2;

  typedef struct packed {
    logic       load;
    logic [2:0] regIdx;
    logic       hiNib;
  } nib_strobe_t;
endpackage

// File: rtl/tpm_decode.sv
module tpm_decode
  import tpm_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  output nib_strobe_t       strobe
);
  logic [3:0] blockSel;
  logic [1:0] pairSel;
  logic       pairHit;
  logic       upperZero;
  logic       slotHit;
  logic       oddReg;
  logic       hiNib;

  assign blockSel  = wrAddr[ADDR_W-1 -: 4];
  assign upperZero = (wrAddr[ADDR_W-5:4] == '0);

  always_comb begin
    pairHit = 1'b1;
    pairSel = 2'd0;
    unique case (blockSel)
      4'hB:    pairSel = 2'd0;
      4'hC:    pairSel = 2'd1;
      4'hD:    pairSel = 2'd2;
      4'hE:    pairSel = 2'd3;
      default: pairHit = 1'b0;
    endcase
  end

  always_comb begin
    slotHit = 1'b1;
    oddReg  = 1'b0;
    hiNib   = 1'b0;
    case (wrAddr[3:0])
      4'h0:       begin oddReg = 1'b0; hiNib = 1'b0; end
      4'h2, 4'h8: begin oddReg = 1'b0; hiNib = 1'b1; end
      4'h1, 4'h4: begin oddReg = 1'b1; hiNib = 1'b0; end
      4'h3, 4'hC: begin oddReg = 1'b1; hiNib = 1'b1; end
      default:    slotHit = 1'b0;
    endcase
  end

  assign strobe.load   = wrEn && pairHit && upperZero && slotHit;
  assign strobe.regIdx = {pairSel, oddReg};
  assign strobe.hiNib  = hiNib;
endmodule

// File: rtl/tpm_regs.sv
module tpm_regs
  import tpm_pkg::*;
#(
  parameter int NUM_WIN   = 8,
  parameter int PAGE_BITS = 7,
  parameter int VADDR_W   = 13
) (
  input  logic               clk,
  input  logic               rst,
  input  nib_strobe_t        strobe,
  input  logic [NIB_W-1:0]   nibData,
  input  logic [VADDR_W-1:0] vidAddr,
  output logic [REG_W-1:0]   pageNum
);
  localparam int WIN_BITS = $clog2(NUM_WIN);
  localparam logic [REG_W-1:0] PAGE_MASK = REG_W'((1 << PAGE_BITS) - 1);

  logic [REG_W-1:0]    bankReg [NUM_WIN];
  logic [WIN_BITS-1:0] winSel;

  for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_bank
    logic hitMe;
    assign hitMe = strobe.load && (32'(strobe.regIdx) == gi);
    always_ff @(posedge clk) begin
      if (rst) begin
        bankReg[gi] <= '0;
      end else if (hitMe) begin
        if (strobe.hiNib) bankReg[gi][REG_W-1:NIB_W] <= nibData;
        else              bankReg[gi][NIB_W-1:0]     <= nibData;
      end
    end
  end

  assign winSel  = vidAddr[VADDR_W-1 -: WIN_BITS];
  assign pageNum = bankReg[winSel] & PAGE_MASK;
endmodule

// File: rtl/tile_page_map.sv
module tile_page_map
  import tpm_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int VADDR_W   = 13,
  parameter int NUM_WIN   = 8,
  parameter int PAGE_BITS = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [7:0]         wrData,
  input  logic [VADDR_W-1:0] vidAddr,
  output logic [7:0]         pageNum
);
  nib_strobe_t strobe;

  tpm_decode #(.ADDR_W(ADDR_W)) uDecode (
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .strobe (strobe)
  );

  tpm_regs #(
    .NUM_WIN   (NUM_WIN),
    .PAGE_BITS (PAGE_BITS),
    .VADDR_W   (VADDR_W)
  ) uRegs (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .nibData (wrData[NIB_W-1:0]),
    .vidAddr (vidAddr),
    .pageNum (pageNum)
  );
endmodule

// File: rtl/tpm_checker.sv
module tpm_checker #(
  parameter int ADDR_W    = 16,
  parameter int VADDR_W   = 13,
  parameter int PAGE_BITS = 7
) (
  input logic               clk,
  input logic               rst,
  input logic               wrEn,
  input logic [ADDR_W-1:0]  wrAddr,
  input logic [7:0]         wrData,
  input logic [VADDR_W-1:0] vidAddr,
  input logic [7:0]         pageNum
);
  localparam logic [7:0] PAGE_MASK = 8'((1 << PAGE_BITS) - 1);

  logic topInBank;
  assign topInBank = (wrAddr[ADDR_W-1 -: 4] >= 4'hB) && (wrAddr[ADDR_W-1 -: 4] <= 4'hE);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (pageNum == 8'h00)); // R1

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wrEn) && $stable(vidAddr)) |-> $stable(pageNum)); // R8

  AST_OUTSIDE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wrEn) && !$past(topInBank) && $stable(vidAddr)) |-> $stable(pageNum)); // R8

  AST_LO_NIBBLE_REG0: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrAddr == 16'hB000) ##1 (vidAddr[VADDR_W-1 -: 3] == 3'd0)
      |-> (pageNum[3:0] == ($past(wrData[3:0]) & PAGE_MASK[3:0]))); // R3

  AST_HI_ALIAS_REG7: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrAddr == 16'hE00C) ##1 (vidAddr[VADDR_W-1 -: 3] == 3'd7)
      |-> (pageNum[7:4] == ($past(wrData[3:0]) & PAGE_MASK[7:4]))); // R6

  AST_PAGE_MASKED: assert property (@(posedge clk) disable iff (rst)
    (pageNum & ~PAGE_MASK) == 8'h00); // R10
endmodule

bind tile_page_map tpm_checker #(
  .ADDR_W    (ADDR_W),
  .VADDR_W   (VADDR_W),
  .PAGE_BITS (PAGE_BITS)
) uChk (
  .clk     (clk),
  .rst     (rst),
  .wrEn    (wrEn),
  .wrAddr  (wrAddr),
  .wrData  (wrData),
  .vidAddr (vidAddr),
  .pageNum (pageNum)
);

// File: tb/sim_tile_page_map.sv
`timescale 1ns/1ps
module sim_tile_page_map;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [15:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic [12:0] vidAddr = '0;
  logic [7:0]  pageNum;

  int checks = 0;
  int failures = 0;
  logic [7:0] model [8];

  always #10 clk = ~clk;  // 50 MHz

  tile_page_map u0 (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .vidAddr(vidAddr), .pageNum(pageNum)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic checkWin(string req, int idx, logic [9:0] lowBits);
    vidAddr = {3'(idx), lowBits};
    #1;
    check(req, pageNum, model[idx] & 8'h7F);
  endtask

  task automatic wrRaw(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic wrNib(logic [15:0] a, logic [7:0] d, int idx, bit hi);
    wrRaw(a, d);
    if (hi) model[idx][7:4] = d[3:0];
    else    model[idx][3:0] = d[3:0];
  endtask

  task automatic t_reset();
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    for (int i = 0; i < 8; i++) checkWin("R1 reset clears", i, 10'(i * 97));
  endtask

  task automatic t_primarySlots();
    for (int p = 0; p < 4; p++) begin
      logic [15:0] base = 16'hB000 + 16'(p) * 16'h1000;
      wrNib(base + 16'h0, 8'(8'h10 + p), 2*p,   1'b0);   // R3
      wrNib(base + 16'h2, 8'(8'h02 + p), 2*p,   1'b1);   // R4
      wrNib(base + 16'h1, 8'(8'h09 - p), 2*p+1, 1'b0);   // R5
      wrNib(base + 16'h3, 8'(8'h04 + p), 2*p+1, 1'b1);   // R6
    end
    for (int i = 0; i < 8; i++) begin
      checkWin("R3/R5 low nibble primary", i, 10'h000);
      checkWin("R2 window select", i, 10'h3FF);
    end
  endtask

  task automatic t_aliasSlots();
    for (int p = 0; p < 4; p++) begin
      logic [15:0] base = 16'hB000 + 16'(p) * 16'h1000;
      wrNib(base + 16'h8, 8'(8'h05 + p), 2*p,   1'b1);   // R4
      wrNib(base + 16'h4, 8'(8'h0C - p), 2*p+1, 1'b0);   // R5
      wrNib(base + 16'hC, 8'(8'h01 + p), 2*p+1, 1'b1);   // R6
    end
    for (int p = 0; p < 4; p++) begin
      checkWin("R4 even high alias", 2*p, 10'h155);
      checkWin("R6 odd high alias, R5 odd low alias", 2*p+1, 10'h2AA);
    end
  endtask

  task automatic t_nibbleKeep();
    wrNib(16'hB000, 8'hF3, 0, 1'b0);
    checkWin("R7 upper data ignored, high kept", 0, 10'h010);
    wrNib(16'hC00C, 8'hA6, 3, 1'b1);
    checkWin("R7 low nibble kept", 3, 10'h020);
    checkWin("R7 neighbour untouched", 2, 10'h020);
  endtask

  task automatic t_ignored();
    wrRaw(16'hB005, 8'h0F);
    wrRaw(16'hB006, 8'h0F);
    wrRaw(16'hB010, 8'h0F);
    wrRaw(16'hC100, 8'h0F);
    wrRaw(16'hA000, 8'h0F);
    wrRaw(16'hF002, 8'h0F);
    wrRaw(16'h7003, 8'h0F);
    for (int i = 0; i < 8; i++) checkWin("R8 unused address ignored", i, 10'h0);
  endtask

  task automatic t_timing();
    vidAddr = {3'd5, 10'h0};
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 16'hD003; wrData = 8'h06;
    #5;
    check("R9 old value before edge", pageNum, model[5] & 8'h7F);
    @(posedge clk);
    #2;
    model[5][7:4] = 4'h6;
    check("R9 new value after edge", pageNum, model[5] & 8'h7F);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic t_mask();
    wrNib(16'hE002, 8'h0F, 6, 1'b1);
    wrNib(16'hE000, 8'h0F, 6, 1'b0);
    checkWin("R10 page masked to 7 bits", 6, 10'h3C0);
    check("R10 bit 7 reads zero", pageNum & 8'h80, 8'h00);
  endtask

  task automatic t_resetAgain();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    for (int i = 0; i < 8; i++) checkWin("R1 reset after use", i, 10'h0);
  endtask

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_primarySlots();
    t_aliasSlots();
    t_nibbleKeep();
    t_ignored();
    t_timing();
    t_mask();
    t_resetAgain();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule